// File: doc/BRIEF.md
# Delay-Slot Fetch Address Sequencer

This block produces the fetch address for a single-issue, 32-bit core whose jumps and branches have one architectural delay slot. In each cycle the core tells the sequencer about the instruction at the current fetch address. It reports whether that instruction is a control transfer and, if so, whether it is taken, whether it is a "likely" variant, and its target. It also reports whether the instruction raised an exception. The sequencer works out the next fetch address. A redirect lands only after the slot instruction. A not-taken likely branch annuls its slot. A fault in a slot is charged to the branch that owns the slot.

An exception saves a return address and a flag that marks a fault inside a slot, then sends fetch to a fixed vector. A stall input freezes all state. A halt input stops the sequencer. While halted, a step pulse runs one instruction, and when that instruction is a control transfer its slot runs as well, so the pair behaves as one unit. A control transfer that sits inside a delay slot does not redirect fetch. It sets a sticky error flag.

Top module: `nps_sequencer`

## Requirements
- R1: After reset, `pc_o` is 0xBFC00000 and `in_slot_o`, `annul_o`, `epc_in_slot_o` and `slot_ct_err_o` are 0.
- R2: An advancing instruction that is not a control transfer and raises no exception moves `pc_o` to `pc_o + 4` in the next cycle, with `in_slot_o` = 0.
- R3: An ordinary taken branch at address B is followed by its slot at B+4 (`in_slot_o` = 1, `annul_o` = 0). Once the slot advances, `pc_o` becomes the branch target.
- R4: An ordinary not-taken branch at B is followed by an executed slot at B+4 (`annul_o` = 0). Then `pc_o` becomes B+8.
- R5: A taken likely branch at B gives an executed slot at B+4 (`annul_o` = 0). Then `pc_o` becomes the target.
- R6: A not-taken likely branch at B gives a slot at B+4 with `annul_o` = 1. Then `pc_o` becomes B+8. While the slot is annulled, the exception and control-transfer inputs have no effect on `pc_o`, `epc_o`, `epc_in_slot_o` or `slot_ct_err_o`.
- R7: An exception on an instruction at address A that is not in a slot sets `epc_o` = A and `epc_in_slot_o` = 0, and moves `pc_o` to 0x80000180.
- R8: An exception on an executed slot instruction whose branch is at B sets `epc_o` = B and `epc_in_slot_o` = 1, and moves `pc_o` to 0x80000180. The pending redirect is dropped.
- R9: A control transfer on an executed slot instruction with no exception gives no redirect (`pc_o` goes to slot+4). It sets `slot_ct_err_o`, which stays at 1 until reset.
- R10: While `stall_i` = 1, `pc_o`, `in_slot_o`, `annul_o` and the pending redirect keep their values.
- R11: While `halt_i` = 1, `pc_o` holds unless `step_i` = 1. A step on a control transfer advances over the transfer and then over its slot, and then holds again. A step on any other instruction advances one address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_i | input | 1 | Freeze all state this cycle |
| halt_i | input | 1 | Halt sequencing except for steps and slots |
| step_i | input | 1 | Run one instruction group while halted |
| ct_valid_i | input | 1 | Instruction at `pc_o` is a control transfer |
| ct_taken_i | input | 1 | The control transfer is taken |
| ct_likely_i | input | 1 | The control transfer is a likely variant |
| ct_target_i | input | 32 | Target address of the control transfer |
| exc_i | input | 1 | Instruction at `pc_o` raised an exception |
| pc_o | output | 32 | Current fetch address |
| in_slot_o | output | 1 | Instruction at `pc_o` is a delay-slot instruction |
| annul_o | output | 1 | Instruction at `pc_o` is an annulled slot |
| epc_o | output | 32 | Saved exception return address |
| epc_in_slot_o | output | 1 | The last exception hit a slot instruction |
| slot_ct_err_o | output | 1 | Sticky flag: control transfer seen inside a slot |

## Verification
A wrong slot-tracking state shows up at the ports within one advancing cycle. The fetch address either jumps to the target one instruction early, arrives one instruction late, or never arrives. `annul_o` or `in_slot_o` also takes the wrong value at the slot address. A wrong fault attribution is visible in `epc_o` and `epc_in_slot_o` on the cycle right after the fault. The bench sweeps every combination of taken, likely, a slot fault and a nested transfer from varied start addresses. It checks the fetch address after both the branch and its slot.

// File: rtl/nps_pkg.sv
package nps_pkg;
  localparam int ADDR_W     = 32;
  localparam int INSTR_BYTES = 4;

  typedef logic [ADDR_W-1:0] addr_t;

  // Address of the instruction that follows a at a fixed instruction width
  function automatic addr_t seq_next(input addr_t a);
    return a + addr_t'(INSTR_BYTES);
  endfunction

  // Address of the branch that owns the slot instruction at a
  function automatic addr_t slot_owner(input addr_t a);
    return a - addr_t'(INSTR_BYTES);
  endfunction

  // Which source feeds the next fetch address
  typedef enum logic [1:0] {
    NXT_SEQ    = 2'd0,
    NXT_TARGET = 2'd1,
    NXT_VECTOR = 2'd2
  } nxt_sel_e;
endpackage

// File: rtl/nps_slot_tracker.sv
module nps_slot_tracker
  import nps_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv_i,
  input  logic  flush_i,
  input  logic  ct_valid_i,
  input  logic  ct_taken_i,
  input  logic  ct_likely_i,
  input  addr_t ct_target_i,
  output logic  in_slot_o,
  output logic  annul_o,
  output logic  redirect_o,
  output addr_t target_o,
  output logic  nested_err_o
);
  logic  in_slot_q, pend_q, annul_q, err_q;
  addr_t tgt_q;

  // Events brought out for the assertions
  logic open_slot, close_slot, nested_ct;
  assign open_slot  = adv_i && !flush_i && !in_slot_q && ct_valid_i;
  assign close_slot = adv_i && in_slot_q;
  assign nested_ct  = adv_i && !flush_i && in_slot_q && !annul_q && ct_valid_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_slot_q <= 1'b0;
      pend_q    <= 1'b0;
      annul_q   <= 1'b0;
      err_q     <= 1'b0;
      tgt_q     <= '0;
    end else if (adv_i) begin
      if (flush_i || in_slot_q) begin
        in_slot_q <= 1'b0;
        pend_q    <= 1'b0;
        annul_q   <= 1'b0;
        if (nested_ct) err_q <= 1'b1;
      end else if (ct_valid_i) begin
        in_slot_q <= 1'b1;
        pend_q    <= ct_taken_i;
        annul_q   <= ct_likely_i && !ct_taken_i;
        tgt_q     <= ct_target_i;
      end
    end
  end

  assign in_slot_o    = in_slot_q;
  assign annul_o      = in_slot_q && annul_q;
  assign redirect_o   = in_slot_q && pend_q;
  assign target_o     = tgt_q;
  assign nested_err_o = err_q;

  assert_slot_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    close_slot |=> !in_slot_o);
  assert_slot_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    open_slot |=> in_slot_o);
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    nested_err_o |=> nested_err_o);
  assert_err_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    nested_ct |=> nested_err_o);
  assert_annul_in_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    annul_o |-> in_slot_o && !redirect_o);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(in_slot_o) && $stable(annul_o) && $stable(redirect_o));
endmodule

// File: rtl/nps_pc_reg.sv
module nps_pc_reg
  import nps_pkg::*;
#(
  parameter addr_t RESET_VEC = 32'hBFC0_0000,
  parameter addr_t EXC_VEC   = 32'h8000_0180
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv_i,
  input  logic  exc_take_i,
  input  logic  redirect_i,
  input  addr_t target_i,
  output addr_t pc_o
);
  addr_t    pc_q, pc_d;
  nxt_sel_e sel;

  always_comb begin
    if (exc_take_i)      sel = NXT_VECTOR;
    else if (redirect_i) sel = NXT_TARGET;
    else                 sel = NXT_SEQ;
  end

  always_comb begin
    unique case (sel)
      NXT_VECTOR: pc_d = EXC_VEC;
      NXT_TARGET: pc_d = target_i;
      default:    pc_d = seq_next(pc_q);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     pc_q <= RESET_VEC;
    else if (adv_i) pc_q <= pc_d;
  end

  assign pc_o = pc_q;

  assert_pc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(pc_o));
  assert_vector_R7: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i && exc_take_i |=> pc_o == EXC_VEC);
endmodule

// File: rtl/nps_epc_unit.sv
module nps_epc_unit
  import nps_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  exc_take_i,
  input  logic  in_slot_i,
  input  addr_t pc_i,
  output addr_t epc_o,
  output logic  epc_in_slot_o
);
  addr_t epc_q;
  logic  slot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc_q  <= '0;
      slot_q <= 1'b0;
    end else if (exc_take_i) begin
      epc_q  <= in_slot_i ? slot_owner(pc_i) : pc_i;
      slot_q <= in_slot_i;
    end
  end

  assign epc_o         = epc_q;
  assign epc_in_slot_o = slot_q;

  assert_epc_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_take_i |=> $stable(epc_o) && $stable(epc_in_slot_o));
endmodule

// File: rtl/nps_sequencer.sv
module nps_sequencer
  import nps_pkg::*;
#(
  parameter addr_t RESET_VEC = 32'hBFC0_0000,
  parameter addr_t EXC_VEC   = 32'h8000_0180
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        stall_i,
  input  logic        halt_i,
  input  logic        step_i,
  input  logic        ct_valid_i,
  input  logic        ct_taken_i,
  input  logic        ct_likely_i,
  input  logic [31:0] ct_target_i,
  input  logic        exc_i,
  output logic [31:0] pc_o,
  output logic        in_slot_o,
  output logic        annul_o,
  output logic [31:0] epc_o,
  output logic        epc_in_slot_o,
  output logic        slot_ct_err_o
);
  // Named internal events
  logic  advance, exc_take, redirect, in_slot, annul;
  addr_t target, pc;

  // A slot always runs together with its branch, even while halted
  assign advance  = !stall_i && (!halt_i || step_i || in_slot);
  // An annulled slot does not execute, so it cannot fault
  assign exc_take = advance && exc_i && !annul;

  nps_slot_tracker u_slot (
    .clk          (clk),
    .rst_n        (rst_n),
    .adv_i        (advance),
    .flush_i      (exc_take),
    .ct_valid_i   (ct_valid_i),
    .ct_taken_i   (ct_taken_i),
    .ct_likely_i  (ct_likely_i),
    .ct_target_i  (ct_target_i),
    .in_slot_o    (in_slot),
    .annul_o      (annul),
    .redirect_o   (redirect),
    .target_o     (target),
    .nested_err_o (slot_ct_err_o)
  );

  nps_pc_reg #(.RESET_VEC(RESET_VEC), .EXC_VEC(EXC_VEC)) u_pc (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv_i      (advance),
    .exc_take_i (exc_take),
    .redirect_i (redirect),
    .target_i   (target),
    .pc_o       (pc)
  );

  nps_epc_unit u_epc (
    .clk           (clk),
    .rst_n         (rst_n),
    .exc_take_i    (exc_take),
    .in_slot_i     (in_slot),
    .pc_i          (pc),
    .epc_o         (epc_o),
    .epc_in_slot_o (epc_in_slot_o)
  );

  assign pc_o      = pc;
  assign in_slot_o = in_slot;
  assign annul_o   = annul;

  assert_redirect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    advance && redirect && !exc_take |=> pc_o == $past(target));
  assert_seq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    advance && !in_slot_o && !exc_take |=> pc_o == $past(pc_o) + 32'd4);
  assert_slot_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take && in_slot_o |=> epc_in_slot_o && epc_o == $past(pc_o) - 32'd4);
  assert_plain_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take && !in_slot_o |=> !epc_in_slot_o && epc_o == $past(pc_o));
  assert_halt_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    halt_i && !step_i && !in_slot_o |=> $stable(pc_o));
  assert_halt_slot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    halt_i && !stall_i && in_slot_o |=> !in_slot_o);
endmodule

// File: tb/test_nps_sequencer.sv
module test_nps_sequencer;
  localparam logic [31:0] RST_V = 32'hBFC0_0000;
  localparam logic [31:0] EXC_V = 32'h8000_0180;

  logic clk = 1'b0, rst_n = 1'b0;
  logic stall = 0, halt = 0, step = 0, ctv = 0, ctt = 0, ctl = 0, exc = 0;
  logic [31:0] tgt = '0;
  logic [31:0] pc, epc;
  logic in_slot, annul, epc_slot, err;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  nps_sequencer i_nps_sequencer (
    .clk(clk), .rst_n(rst_n), .stall_i(stall), .halt_i(halt), .step_i(step),
    .ct_valid_i(ctv), .ct_taken_i(ctt), .ct_likely_i(ctl), .ct_target_i(tgt),
    .exc_i(exc), .pc_o(pc), .in_slot_o(in_slot), .annul_o(annul),
    .epc_o(epc), .epc_in_slot_o(epc_slot), .slot_ct_err_o(err));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Present one instruction's decode for one clock, then clear the inputs
  task automatic cyc(input logic v, input logic t, input logic l,
                     input logic [31:0] ta, input logic e, input logic s);
    ctv = v; ctt = t; ctl = l; tgt = ta; exc = e; step = s;
    @(posedge clk); #1;
    ctv = 0; ctt = 0; ctl = 0; tgt = '0; exc = 0; step = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] b, ta, epcx, exp_pc;
    logic errx, epcsx, ann;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    chk("R1 pc", pc, RST_V);
    chk("R1 in_slot", {31'd0, in_slot}, 0);
    chk("R1 annul", {31'd0, annul}, 0);
    chk("R1 epc_slot", {31'd0, epc_slot}, 0);
    chk("R1 err", {31'd0, err}, 0);

    // R2 sequential flow
    for (int i = 0; i < 4; i++) begin
      b = pc;
      cyc(0, 0, 0, '0, 0, 0);
      chk("R2 seq", pc, b + 32'd4);
      chk("R2 no slot", {31'd0, in_slot}, 0);
    end

    // R7 fault outside a slot
    b = pc;
    cyc(0, 0, 0, '0, 1, 0);
    chk("R7 vector", pc, EXC_V);
    chk("R7 epc", epc, b);
    chk("R7 epc_slot", {31'd0, epc_slot}, 0);
    epcx = b; epcsx = 0; errx = 0;

    // R3 R4 R5 R6 R8 R9 sweep: taken x likely x slot fault x nested transfer
    for (int k = 0; k < 32; k++) begin
      logic t, l, e, c;
      t = k[0]; l = k[1]; e = k[2]; c = k[3];
      b = pc;
      ta = 32'h0040_0000 + (k << 8);
      cyc(1, t, l, ta, 0, 0);
      ann = l && !t;
      chk("R3 slot addr", pc, b + 32'd4);
      chk("R3 in_slot", {31'd0, in_slot}, 1);
      chk(ann ? "R6 annul set" : "R5 annul clear", {31'd0, annul}, {31'd0, ann});
      cyc(c, 1, 0, 32'h1234_5670, e, 0);
      if (ann) exp_pc = b + 32'd8;
      else if (e) begin exp_pc = EXC_V; epcx = b; epcsx = 1; end
      else begin
        exp_pc = t ? ta : b + 32'd8;
        if (c) errx = 1;
      end
      chk(ann ? "R6 after annul" : (e ? "R8 vector" : (t ? "R3 target" : "R4 fallthrough")), pc, exp_pc);
      chk(ann ? "R6 epc untouched" : "R8 epc", epc, epcx);
      chk("R8 epc_slot", {31'd0, epc_slot}, {31'd0, epcsx});
      chk("R9 err", {31'd0, err}, {31'd0, errx});
      chk("R3 slot closed", {31'd0, in_slot}, 0);
    end

    // R10 stall with pending redirect
    b = pc;
    cyc(1, 1, 0, 32'h0000_2000, 0, 0);
    stall = 1;
    cyc(1, 0, 0, 32'h0000_3000, 1, 0);
    chk("R10 pc held", pc, b + 32'd4);
    chk("R10 slot held", {31'd0, in_slot}, 1);
    cyc(0, 0, 0, '0, 0, 0);
    chk("R10 pc held2", pc, b + 32'd4);
    stall = 0;
    cyc(0, 0, 0, '0, 0, 0);
    chk("R10 redirect kept", pc, 32'h0000_2000);

    // R11 halt and grouped step
    halt = 1;
    b = pc;
    cyc(0, 0, 0, '0, 0, 0);
    chk("R11 halted", pc, b);
    cyc(0, 0, 0, '0, 0, 1);
    chk("R11 plain step", pc, b + 32'd4);
    cyc(0, 0, 0, '0, 0, 0);
    chk("R11 hold after step", pc, b + 32'd4);
    b = pc;
    cyc(1, 1, 0, 32'h0000_5000, 0, 1);
    chk("R11 step into slot", pc, b + 32'd4);
    cyc(0, 0, 0, '0, 0, 0);
    chk("R11 slot auto-runs", pc, 32'h0000_5000);
    cyc(0, 0, 0, '0, 0, 0);
    chk("R11 hold after group", pc, 32'h0000_5000);
    halt = 0;

    // R9 sticky until reset, then R1 again
    cyc(0, 0, 0, '0, 0, 0);
    chk("R9 still set", {31'd0, err}, {31'd0, errx});
    rst_n = 0;
    cyc(0, 0, 0, '0, 0, 0);
    rst_n = 1;
    chk("R1 pc after reset", pc, RST_V);
    chk("R1 err cleared", {31'd0, err}, 0);

    finish_run();
  end
endmodule